// File: doc/BRIEF.md
# Multiplex Section Overhead Receive Monitor

This block sits on the receive side of a 155 Mbit/s synchronous line after framing and descrambling. It receives one byte per valid cycle, tagged with its row (1 to 9) and column (1 to `COLS`). It checks the multiplex-section parity and takes the protection-switching bits out of K1 and K2. It filters the defect code in K2 bits 6 to 8 into alarm indication (AIS) and remote defect indication (RDI) flags. It also tracks errored blocks over a window of frames.

The parity is split into `LANES` interleaved 8-bit lanes; lane k covers the columns with (column-1) mod `LANES` = k. Each lane is checked against the B2 byte at row 5, column k+1, of the next frame. The block reports the number of bad parity bits for the return M1 byte and the code to return in K2 bits 6 to 8. It passes the byte stream on with one register stage and replaces it with all ones while AIS or the excessive-error flag is set.

The defect filter is a three-state machine. NORMAL goes to AIS_HELD on 5 consecutive 111 codes, and to RDI_HELD on 5 consecutive 110 codes. AIS_HELD leaves after 5 consecutive codes that are not 111: it goes to RDI_HELD if those 5 codes were all 110, and to NORMAL otherwise. RDI_HELD goes to AIS_HELD on 5 consecutive 111 codes, and to NORMAL on 5 consecutive codes that are not 110. All other K2 bytes keep the state.

Top module: `msoh_rx_monitor`

## Requirements
- R1: For every frame after the first since reset, `m1_valid` pulses for one cycle, one cycle after the byte at row 5, column `LANES`. `m1_count` then equals the number of bits (0 to 24) in which the B2 bytes differ from the even parity of their lane over the previous frame. No pulse follows the first frame.
- R2: Parity covers every byte of the frame, B2 bytes included, except rows 1 to 3 at columns 1 to 9. Values in that corner never affect `m1_count`.
- R3: A frame with nonzero `m1_count` is one errored block. At the end of each window of `WINDOW` checked frames, `ms_exc` becomes 1 if the errored blocks in that window exceed `exc_limit`, and becomes 0 otherwise. It does not change inside a window.
- R4: K2 is row 5, column 2·`LANES`+1, and its bits 6 to 8 are `in_data[2:0]`. `ms_ais` sets after 5 consecutive K2 codes of 111 and clears after 5 consecutive codes that are not 111. It changes one cycle after a K2 byte.
- R5: `ms_rdi` sets after 5 consecutive codes of 110 and clears after 5 consecutive codes that are not 110. Any other code in between restarts the count. `ms_rdi` and `ms_ais` are never both set.
- R6: One cycle after the K1 byte (row 5, column `LANES`+1), `aps_k1` holds that byte. One cycle after the K2 byte, `aps_k2` holds K2 bits 1 to 5 (`in_data[7:3]`).
- R7: `out_valid` and `out_data` follow `in_valid` and `in_data` one cycle later. `out_data` is 8'hFF when `ms_ais` or `ms_exc` was set at the input byte; RDI alone does not squelch.
- R8: `k2_return` is 3'b110 while `ms_ais` is set and 3'b000 otherwise.
- R9: After reset all flags, `m1_valid`, `out_valid` and `k2_return` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte strobe |
| in_data | input | 8 | Descrambled frame byte |
| in_row | input | 4 | Row of the byte, 1 to 9 |
| in_col | input | $clog2(COLS+1) | Column of the byte, 1 to COLS |
| exc_limit | input | $clog2(WINDOW+1) | Errored-block limit per window |
| out_valid | output | 1 | Delayed byte strobe |
| out_data | output | 8 | Delayed byte or all ones |
| aps_k1 | output | 8 | Last K1 byte |
| aps_k2 | output | 5 | Last K2 bits 1 to 5 |
| ms_ais | output | 1 | Section alarm indication |
| ms_rdi | output | 1 | Remote defect indication |
| ms_exc | output | 1 | Excessive-error flag |
| m1_valid | output | 1 | Parity result strobe |
| m1_count | output | $clog2(8*LANES+1) | Bad parity bits for return in M1 |
| k2_return | output | 3 | Code for return in K2 bits 6 to 8 |

## Verification
The results arrive at fixed delays. The parity count comes one cycle after the last B2 byte. AIS, RDI and the protection bytes come one cycle after the K1 or K2 byte. The excessive-error flag comes two cycles after the last B2 byte of a window's final frame. The squelched or passed data comes one cycle after its input byte. The scoreboard queues each expected count as the B2 bytes are sent and pops it on the negative edge where `m1_valid` is high. Flags, protection bits and squelch are sampled on the negative edge of an idle cycle after each frame's last byte, by which time every delay above has passed. The persistence cases are checked on the fourth and fifth frames of each run.

// File: rtl/msoh_pkg.sv
package msoh_pkg;
    typedef enum logic [1:0] {
        DS_NORMAL   = 2'd0,
        DS_AIS_HELD = 2'd1,
        DS_RDI_HELD = 2'd2
    } defect_state_t;

    localparam logic [2:0] CODE_AIS  = 3'b111;
    localparam logic [2:0] CODE_RDI  = 3'b110;
    localparam int         PERSIST   = 5;
    localparam int         SOH_ROW   = 5;
    localparam int         RS_ROWS   = 3;
    localparam int         OH_COLS   = 9;
endpackage

// File: rtl/msoh_bip_check.sv
module msoh_bip_check
    import msoh_pkg::*;
#(
    parameter int COLS  = 270,
    parameter int LANES = 3,
    parameter int RW    = 4,
    parameter int CW    = 9,
    parameter int EW    = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [7:0]    in_data,
    input  logic [RW-1:0] in_row,
    input  logic [CW-1:0] in_col,
    output logic          chk_done,
    output logic [EW-1:0] bit_errs
);
    logic [CW-1:0] col_off;
    logic [CW-1:0] lane_sel;
    logic          in_rsoh;
    logic          last_byte;
    logic          is_b2;
    logic          prev_ok;
    logic [EW-1:0] err_acc;
    logic [EW-1:0] ones;
    logic [EW-1:0] total;
    logic [7:0]    mis [LANES];

    assign col_off   = in_col - CW'(1);
    assign lane_sel  = col_off % CW'(LANES);
    assign in_rsoh   = (in_row <= RW'(RS_ROWS)) && (in_col <= CW'(OH_COLS));
    assign last_byte = (in_row == RW'(9)) && (in_col == CW'(COLS));
    assign is_b2     = in_valid && (in_row == RW'(SOH_ROW)) &&
                       (in_col >= CW'(1)) && (in_col <= CW'(LANES));

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [7:0] acc_q, prev_q, acc_nx;
        logic       hit;
        assign hit    = in_valid && !in_rsoh && (lane_sel == CW'(g));
        assign acc_nx = hit ? (acc_q ^ in_data) : acc_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                acc_q  <= '0;
                prev_q <= '0;
            end else if (in_valid && last_byte) begin
                prev_q <= acc_nx;
                acc_q  <= '0;
            end else begin
                acc_q  <= acc_nx;
            end
        end
        assign mis[g] = (is_b2 && in_col == CW'(g + 1)) ? (in_data ^ prev_q) : 8'h00;
    end

    always_comb begin
        ones = '0;
        for (int g = 0; g < LANES; g++) begin
            ones = ones + EW'($countones(mis[g]));
        end
        total = ((in_col == CW'(1)) ? '0 : err_acc) + ones;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_ok  <= 1'b0;
            err_acc  <= '0;
            chk_done <= 1'b0;
            bit_errs <= '0;
        end else begin
            chk_done <= 1'b0;
            if (in_valid && last_byte) prev_ok <= 1'b1;
            if (is_b2) begin
                err_acc <= total;
                if (in_col == CW'(LANES) && prev_ok) begin
                    chk_done <= 1'b1;
                    bit_errs <= total;
                end
            end
        end
    end
endmodule

// File: rtl/msoh_k_monitor.sv
module msoh_k_monitor
    import msoh_pkg::*;
#(
    parameter int LANES = 3,
    parameter int RW    = 4,
    parameter int CW    = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [7:0]    in_data,
    input  logic [RW-1:0] in_row,
    input  logic [CW-1:0] in_col,
    output logic [7:0]    aps_k1,
    output logic [4:0]    aps_k2,
    output logic          ms_ais,
    output logic          ms_rdi
);
    localparam int PW     = $clog2(PERSIST + 1);
    localparam int K1_COL = LANES + 1;
    localparam int K2_COL = 2 * LANES + 1;

    defect_state_t state_q, state_nx;
    logic          k1_hit, k2_hit;
    logic [2:0]    code;
    logic [PW-1:0] ais_run, nais_run, rdi_run, nrdi_run;
    logic [PW-1:0] ais_nx, nais_nx, rdi_nx, nrdi_nx;

    assign k1_hit = in_valid && in_row == RW'(SOH_ROW) && in_col == CW'(K1_COL);
    assign k2_hit = in_valid && in_row == RW'(SOH_ROW) && in_col == CW'(K2_COL);
    assign code   = in_data[2:0];

    function automatic logic [PW-1:0] bump(input logic cond, input logic [PW-1:0] run);
        if (!cond) return '0;
        return (run == PW'(PERSIST)) ? run : run + PW'(1);
    endfunction

    assign ais_nx  = bump(code == CODE_AIS, ais_run);
    assign nais_nx = bump(code != CODE_AIS, nais_run);
    assign rdi_nx  = bump(code == CODE_RDI, rdi_run);
    assign nrdi_nx = bump(code != CODE_RDI, nrdi_run);

    always_comb begin
        state_nx = state_q;
        if (k2_hit) begin
            unique case (state_q)
                DS_NORMAL: begin
                    if (ais_nx == PW'(PERSIST))      state_nx = DS_AIS_HELD;
                    else if (rdi_nx == PW'(PERSIST)) state_nx = DS_RDI_HELD;
                end
                DS_AIS_HELD: begin
                    if (nais_nx == PW'(PERSIST))
                        state_nx = (rdi_nx == PW'(PERSIST)) ? DS_RDI_HELD : DS_NORMAL;
                end
                DS_RDI_HELD: begin
                    if (ais_nx == PW'(PERSIST))       state_nx = DS_AIS_HELD;
                    else if (nrdi_nx == PW'(PERSIST)) state_nx = DS_NORMAL;
                end
                default: state_nx = DS_NORMAL;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= DS_NORMAL;
            ais_run  <= '0;
            nais_run <= '0;
            rdi_run  <= '0;
            nrdi_run <= '0;
            aps_k1   <= '0;
            aps_k2   <= '0;
        end else begin
            state_q <= state_nx;
            if (k1_hit) aps_k1 <= in_data;
            if (k2_hit) begin
                aps_k2   <= in_data[7:3];
                ais_run  <= ais_nx;
                nais_run <= nais_nx;
                rdi_run  <= rdi_nx;
                nrdi_run <= nrdi_nx;
            end
        end
    end

    always_comb begin
        ms_ais = (state_q == DS_AIS_HELD);
        ms_rdi = (state_q == DS_RDI_HELD);
    end
endmodule

// File: rtl/msoh_exc_monitor.sv
module msoh_exc_monitor #(
    parameter int WINDOW = 8000,
    parameter int EW     = 5,
    parameter int CNT_W  = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chk_done,
    input  logic [EW-1:0]    bit_errs,
    input  logic [CNT_W-1:0] exc_limit,
    output logic             ms_exc
);
    logic [CNT_W-1:0] win_q, blk_q, blk_nx;

    assign blk_nx = blk_q + CNT_W'(bit_errs != '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q  <= '0;
            blk_q  <= '0;
            ms_exc <= 1'b0;
        end else if (chk_done) begin
            if (win_q == CNT_W'(WINDOW - 1)) begin
                ms_exc <= (blk_nx > exc_limit);
                win_q  <= '0;
                blk_q  <= '0;
            end else begin
                win_q  <= win_q + CNT_W'(1);
                blk_q  <= blk_nx;
            end
        end
    end
endmodule

// File: rtl/msoh_rx_monitor.sv
module msoh_rx_monitor
    import msoh_pkg::*;
#(
    parameter int COLS   = 270,
    parameter int LANES  = 3,
    parameter int WINDOW = 8000,
    localparam int RW    = 4,
    localparam int CW    = $clog2(COLS + 1),
    localparam int EW    = $clog2(8 * LANES + 1),
    localparam int CNT_W = $clog2(WINDOW + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    input  logic [RW-1:0]    in_row,
    input  logic [CW-1:0]    in_col,
    input  logic [CNT_W-1:0] exc_limit,
    output logic             out_valid,
    output logic [7:0]       out_data,
    output logic [7:0]       aps_k1,
    output logic [4:0]       aps_k2,
    output logic             ms_ais,
    output logic             ms_rdi,
    output logic             ms_exc,
    output logic             m1_valid,
    output logic [EW-1:0]    m1_count,
    output logic [2:0]       k2_return
);
    msoh_bip_check #(.COLS(COLS), .LANES(LANES), .RW(RW), .CW(CW), .EW(EW)) u_bip (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_data  (in_data),
        .in_row   (in_row),
        .in_col   (in_col),
        .chk_done (m1_valid),
        .bit_errs (m1_count)
    );

    msoh_k_monitor #(.LANES(LANES), .RW(RW), .CW(CW)) u_kmon (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_data  (in_data),
        .in_row   (in_row),
        .in_col   (in_col),
        .aps_k1   (aps_k1),
        .aps_k2   (aps_k2),
        .ms_ais   (ms_ais),
        .ms_rdi   (ms_rdi)
    );

    msoh_exc_monitor #(.WINDOW(WINDOW), .EW(EW), .CNT_W(CNT_W)) u_exc (
        .clk       (clk),
        .rst_n     (rst_n),
        .chk_done  (m1_valid),
        .bit_errs  (m1_count),
        .exc_limit (exc_limit),
        .ms_exc    (ms_exc)
    );

    assign k2_return = ms_ais ? CODE_RDI : 3'b000;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            out_data  <= (ms_ais || ms_exc) ? 8'hFF : in_data;
        end
    end
endmodule

// File: rtl/msoh_rx_monitor_chk.sv
module msoh_rx_monitor_chk #(
    parameter int COLS   = 270,
    parameter int LANES  = 3,
    parameter int WINDOW = 8000,
    localparam int RW    = 4,
    localparam int CW    = $clog2(COLS + 1),
    localparam int EW    = $clog2(8 * LANES + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic [7:0]    in_data,
    input logic [RW-1:0] in_row,
    input logic [CW-1:0] in_col,
    input logic          out_valid,
    input logic [7:0]    out_data,
    input logic [7:0]    aps_k1,
    input logic          ms_ais,
    input logic          ms_rdi,
    input logic          ms_exc,
    input logic          m1_valid,
    input logic [EW-1:0] m1_count
);
    logic k1_byte, k2_byte, b2_last;
    assign k1_byte = in_valid && in_row == RW'(5) && in_col == CW'(LANES + 1);
    assign k2_byte = in_valid && in_row == RW'(5) && in_col == CW'(2 * LANES + 1);
    assign b2_last = in_valid && in_row == RW'(5) && in_col == CW'(LANES);

    p_m1_timing_r1: assert property (@(posedge clk) disable iff (!rst_n)
        m1_valid |-> $past(b2_last));
    p_m1_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        m1_valid |-> (m1_count <= EW'(8 * LANES)));
    p_exc_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ms_exc != $past(ms_exc)) |-> $past(m1_valid));
    p_ais_on_k2_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ms_ais != $past(ms_ais)) |-> $past(k2_byte));
    p_rdi_on_k2_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ms_rdi != $past(ms_rdi)) |-> $past(k2_byte));
    p_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(ms_ais && ms_rdi));
    p_k1_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (aps_k1 != $past(aps_k1)) |-> $past(k1_byte));
    p_squelch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (ms_ais || ms_exc)) |=> (out_data == 8'hFF));
    p_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !ms_ais && !ms_exc) |=> (out_data == $past(in_data)));
    p_valid_pipe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
endmodule

bind msoh_rx_monitor msoh_rx_monitor_chk #(.COLS(COLS), .LANES(LANES), .WINDOW(WINDOW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_row    (in_row),
    .in_col    (in_col),
    .out_valid (out_valid),
    .out_data  (out_data),
    .aps_k1    (aps_k1),
    .ms_ais    (ms_ais),
    .ms_rdi    (ms_rdi),
    .ms_exc    (ms_exc),
    .m1_valid  (m1_valid),
    .m1_count  (m1_count)
);

// File: tb/msoh_rx_monitor_bench.sv
module msoh_rx_monitor_bench;
    localparam int COLS   = 12;
    localparam int LANES  = 3;
    localparam int WINDOW = 4;
    localparam int CW     = $clog2(COLS + 1);
    localparam int EW     = $clog2(8 * LANES + 1);
    localparam int CNT_W  = $clog2(WINDOW + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic [7:0]       in_data = '0;
    logic [3:0]       in_row = '0;
    logic [CW-1:0]    in_col = '0;
    logic [CNT_W-1:0] exc_limit = CNT_W'(2);
    logic             out_valid, ms_ais, ms_rdi, ms_exc, m1_valid;
    logic [7:0]       out_data, aps_k1;
    logic [4:0]       aps_k2;
    logic [EW-1:0]    m1_count;
    logic [2:0]       k2_return;

    int n_chk = 0;
    int n_err = 0;
    int frame_no = 0;
    bit done = 0;
    logic [7:0] bip [LANES];
    bit bip_ok = 0;
    logic [7:0] last_d;
    int exp_q [$];

    always #10 clk = ~clk; // 20 ns period, 50 MHz

    msoh_rx_monitor #(.COLS(COLS), .LANES(LANES), .WINDOW(WINDOW)) u_msoh_rx_monitor (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_row(in_row), .in_col(in_col), .exc_limit(exc_limit),
        .out_valid(out_valid), .out_data(out_data), .aps_k1(aps_k1), .aps_k2(aps_k2),
        .ms_ais(ms_ais), .ms_rdi(ms_rdi), .ms_exc(ms_exc),
        .m1_valid(m1_valid), .m1_count(m1_count), .k2_return(k2_return)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pay(input int f, input int r, input int c);
        return 8'(f * 37 + r * 11 + c * 5 + 3);
    endfunction

    // Driver: sends one frame, queues the expected parity count
    task automatic send_frame(input logic [7:0] k1, input logic [7:0] k2, input logic [23:0] mask);
        logic [7:0] acc [LANES];
        for (int g = 0; g < LANES; g++) acc[g] = 8'h00;
        for (int r = 1; r <= 9; r++) begin
            for (int c = 1; c <= COLS; c++) begin
                logic [7:0] d;
                d = pay(frame_no, r, c);
                if (r == 5 && c <= LANES) begin
                    d = bip_ok ? (bip[c-1] ^ mask[8*(c-1) +: 8]) : 8'hA5;
                    if (c == 1 && bip_ok) exp_q.push_back($countones(mask));
                end
                if (r == 5 && c == LANES + 1) d = k1;
                if (r == 5 && c == 2 * LANES + 1) d = k2;
                @(posedge clk); #1;
                in_valid = 1'b1; in_data = d; in_row = 4'(r); in_col = CW'(c);
                if (!(r <= 3 && c <= 9)) acc[(c-1) % LANES] = acc[(c-1) % LANES] ^ d;
                last_d = d;
            end
        end
        for (int g = 0; g < LANES; g++) bip[g] = acc[g];
        bip_ok = 1;
        frame_no++;
        @(posedge clk); #1;
        in_valid = 1'b0;
        @(negedge clk);
    endtask

    // Monitor: pops expected counts when results appear
    always @(negedge clk) begin
        if (rst_n && m1_valid) begin
            if (exp_q.size() == 0) chk(1'b0, "R1 unexpected m1_valid", 1, 0);
            else begin
                int e;
                e = exp_q.pop_front();
                chk(int'(m1_count) == e, "R1/R2 m1_count", int'(m1_count), e);
            end
        end
    end

    task automatic flags(input string req, input bit a, input bit r, input bit x);
        chk(ms_ais == a, {req, " ms_ais"}, int'(ms_ais), int'(a));
        chk(ms_rdi == r, {req, " ms_rdi"}, int'(ms_rdi), int'(r));
        chk(ms_exc == x, {req, " ms_exc"}, int'(ms_exc), int'(x));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        flags("R9", 0, 0, 0);
        chk(!out_valid && !m1_valid, "R9 out_valid/m1_valid", int'(out_valid | m1_valid), 0);
        chk(k2_return == 3'b000, "R9 k2_return", int'(k2_return), 0);

        send_frame(8'h11, 8'h00, 24'h0);            // f0: no check (R1)
        send_frame(8'h3C, 8'hA8, 24'h0);            // f1: clean, RSOH varies (R2)
        chk(aps_k1 == 8'h3C, "R6 aps_k1", int'(aps_k1), 8'h3C);
        chk(aps_k2 == 5'd21, "R6 aps_k2", int'(aps_k2), 21);
        send_frame(8'hC5, 8'h50, 24'h000001);       // f2: 1 bit
        chk(aps_k1 == 8'hC5, "R6 aps_k1", int'(aps_k1), 8'hC5);
        chk(aps_k2 == 5'd10, "R6 aps_k2", int'(aps_k2), 10);
        send_frame(8'h00, 8'h00, 24'h010203);       // f3: 4 bits over lanes
        send_frame(8'h00, 8'h00, 24'h0);            // f4: window 1 = 2 blocks
        flags("R3 at limit", 0, 0, 0);
        chk(out_data == last_d, "R7 pass", int'(out_data), int'(last_d));
        send_frame(8'h00, 8'h00, 24'hFFFFFF);       // f5: 24 bits
        send_frame(8'h00, 8'h00, 24'h000080);
        send_frame(8'h00, 8'h00, 24'h800000);       // f7: 3 blocks, mid-window
        flags("R3 mid-window", 0, 0, 0);
        send_frame(8'h00, 8'h00, 24'h0);            // f8: window end
        flags("R3 over limit", 0, 0, 1);
        chk(out_data == 8'hFF, "R7 exc squelch", int'(out_data), 255);
        for (int i = 0; i < 4; i++) send_frame(8'h00, 8'h00, 24'h0);
        flags("R3 clear", 0, 0, 0);
        chk(out_data == last_d, "R7 pass after clear", int'(out_data), int'(last_d));

        for (int i = 0; i < 4; i++) send_frame(8'h00, 8'h0F, 24'h0);
        flags("R4 four 111", 0, 0, 0);
        send_frame(8'h00, 8'h0F, 24'h0);
        flags("R4 five 111", 1, 0, 0);
        chk(k2_return == 3'b110, "R8 return on ais", int'(k2_return), 6);
        chk(out_data == 8'hFF, "R7 ais squelch", int'(out_data), 255);
        chk(aps_k2 == 5'd1, "R6 aps_k2", int'(aps_k2), 1);
        for (int i = 0; i < 4; i++) send_frame(8'h00, 8'h00, 24'h0);
        flags("R4 four clear", 1, 0, 0);
        send_frame(8'h00, 8'h00, 24'h0);
        flags("R4 cleared", 0, 0, 0);
        chk(k2_return == 3'b000, "R8 return idle", int'(k2_return), 0);

        for (int i = 0; i < 4; i++) send_frame(8'h00, 8'h06, 24'h0);
        flags("R5 four 110", 0, 0, 0);
        send_frame(8'h00, 8'h00, 24'h0);
        for (int i = 0; i < 4; i++) send_frame(8'h00, 8'h06, 24'h0);
        flags("R5 interrupted", 0, 0, 0);
        send_frame(8'h00, 8'h06, 24'h0);
        flags("R5 five 110", 0, 1, 0);
        chk(k2_return == 3'b000, "R8 no return on rdi", int'(k2_return), 0);
        chk(out_data == last_d, "R7 rdi no squelch", int'(out_data), int'(last_d));
        for (int i = 0; i < 4; i++) send_frame(8'h00, 8'h00, 24'h0);
        flags("R5 four clear", 0, 1, 0);
        send_frame(8'h00, 8'h00, 24'h0);
        flags("R5 cleared", 0, 0, 0);

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R1 pending results", exp_q.size(), 0);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (200000) @(posedge clk);
                chk(1'b0, "watchdog", 0, 1);
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule